// File: doc/BRIEF.md
# Cascadable 4-Bit Magnitude Comparator with 12-Bit Serial and Parallel Assemblies

The block compares two unsigned operands four bits at a time. Each slice reports one of three relations: the first operand is greater, the operands are equal, or the first operand is smaller. Each slice also takes the same three-signal relation from a less significant slice. When a slice's own nibbles are equal, it passes that incoming relation through. When they differ, the slice's own result decides.

The top level builds a 12-bit unsigned comparator in two independent ways and exposes both results.

- **Serial form:** three slices form a ripple chain running from the low nibble up to the high nibble.
- **Parallel form:** three slices compare the three nibble groups at the same time. A fourth merging slice then combines their results. The merging slice treats each group's greater flag as an operand-A bit and its smaller flag as an operand-B bit, and keeps the groups' significance order.

The block is purely combinational and has no clock or reset. Signed comparison is not supported.

Top module: `mag_cmp12`

## Requirements
- R1: Within an operand, the most significant differing bit alone decides the relation. For example, 12'h800 is greater than 12'h7FF.
- R2: The greater output is 1 when A > B (unsigned), or when A = B and the incoming greater relation is 1.
- R3: The equal output is 1 only when A = B and the incoming equal relation is 1.
- R4: The smaller output is 1 when A < B, or when A = B and the incoming smaller relation is 1.
- R5: In the serial form, bits 3..0 feed the slice for bits 7..4, which feeds the slice for bits 11..8. A lower nibble decides only when every higher nibble is equal.
- R6: In the parallel form, group g (bits 4g+3..4g) drives bit g of the merging slice. The group's greater flag is on operand A and its smaller flag is on operand B. The unused merging bit 3 is tied to 0 on both operands.
- R7: For every operand pair, the serial outputs and the parallel outputs are identical.
- R8: For every operand pair, exactly one of greater, equal and smaller is 1 in each form.
- R9: The least significant slices have their incoming relation tied to equal = 1, greater = 0, smaller = 0. As a result, identical 12-bit operands report equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 12 | Operand A, unsigned |
| b_in | input | 12 | Operand B, unsigned |
| ser_gt | output | 1 | Serial form: A > B |
| ser_eq | output | 1 | Serial form: A = B |
| ser_lt | output | 1 | Serial form: A < B |
| par_gt | output | 1 | Parallel form: A > B |
| par_eq | output | 1 | Parallel form: A = B |
| par_lt | output | 1 | Parallel form: A < B |

## Verification
The hardest cases to reach from the ports are those where the incoming relation must carry the answer. This happens when one or two upper nibbles are equal and a lower nibble differs by only its least significant bit. Random operands almost never produce that situation.

The stimulus builds it on purpose. It copies A's upper nibbles into B and then perturbs a single lower bit. It also walks a single differing bit across all twelve positions, with a contradicting pattern below it.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_bit.sv
module cmp_bit (
    input  logic a_bit,
    input  logic b_bit,
    output logic bit_gt,
    output logic bit_lt,
    output logic bit_eq
);
    always_comb begin
        bit_gt = a_bit & ~b_bit;
        bit_lt = ~a_bit & b_bit;
        bit_eq = ~(a_bit ^ b_bit);
    end
endmodule

// File: rtl/mag_slice.sv
module mag_slice
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    input  rel_t         rel_in,
    output rel_t         rel_out
);
    logic [W-1:0] bgt, blt, beq;

    for (genvar i = 0; i < W; i++) begin : g_bit
        cmp_bit u_bit (
            .a_bit  (a_op[i]),
            .b_bit  (b_op[i]),
            .bit_gt (bgt[i]),
            .bit_lt (blt[i]),
            .bit_eq (beq[i])
        );
    end

    always_comb begin
        logic gt_acc;
        logic lt_acc;
        logic still_eq;
        gt_acc   = 1'b0;
        lt_acc   = 1'b0;
        still_eq = 1'b1;
        // MSB-first scan: the first differing bit settles the relation (R1)
        for (int i = W - 1; i >= 0; i--) begin
            gt_acc   = gt_acc | (still_eq & bgt[i]);
            lt_acc   = lt_acc | (still_eq & blt[i]);
            still_eq = still_eq & beq[i];
        end
        rel_out.gt = gt_acc | (still_eq & rel_in.gt);
        rel_out.eq = still_eq & rel_in.eq;
        rel_out.lt = lt_acc | (still_eq & rel_in.lt);

        p_greater_r2: assert (!(a_op > b_op) || (rel_out.gt && !rel_out.eq && !rel_out.lt))
            else $error("p_greater_r2 violated");
        p_equal_pass_r3: assert (!(a_op == b_op) || (rel_out == rel_in))
            else $error("p_equal_pass_r3 violated");
        p_smaller_r4: assert (!(a_op < b_op) || (rel_out.lt && !rel_out.eq && !rel_out.gt))
            else $error("p_smaller_r4 violated");
        p_onehot_keep_r8: assert (($countones(rel_in) != 1) || ($countones(rel_out) == 1))
            else $error("p_onehot_keep_r8 violated");
    end
endmodule

// File: rtl/mag_chain.sv
module mag_chain
    import cmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic [TOTAL_W-1:0] a_op,
    input  logic [TOTAL_W-1:0] b_op,
    output rel_t               rel_out
);
    rel_t link [NUM_SLICES+1];

    assign link[0] = REL_TIE;  // R9: least significant slice tie-off

    // R5: ripple from the low nibble toward the high nibble
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_stage
        mag_slice #(.W(SLICE_W)) u_slice (
            .a_op    (a_op[s*SLICE_W +: SLICE_W]),
            .b_op    (b_op[s*SLICE_W +: SLICE_W]),
            .rel_in  (link[s]),
            .rel_out (link[s+1])
        );
    end

    assign rel_out = link[NUM_SLICES];
endmodule

// File: rtl/mag_tree.sv
module mag_tree
    import cmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic [TOTAL_W-1:0] a_op,
    input  logic [TOTAL_W-1:0] b_op,
    output rel_t               rel_out
);
    rel_t grp [NUM_SLICES];
    logic [SLICE_W-1:0] merge_a, merge_b;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_group
        mag_slice #(.W(SLICE_W)) u_group (
            .a_op    (a_op[g*SLICE_W +: SLICE_W]),
            .b_op    (b_op[g*SLICE_W +: SLICE_W]),
            .rel_in  (REL_TIE),
            .rel_out (grp[g])
        );
    end

    always_comb begin
        merge_a = '0;
        merge_b = '0;
        for (int g = 0; g < NUM_SLICES; g++) begin
            merge_a[g] = grp[g].gt;  // R6: group order kept
            merge_b[g] = grp[g].lt;
            p_group_eq_r6: assert (!grp[g].eq || (!grp[g].gt && !grp[g].lt))
                else $error("p_group_eq_r6 violated");
        end
    end

    mag_slice #(.W(SLICE_W)) u_merge (
        .a_op    (merge_a),
        .b_op    (merge_b),
        .rel_in  (REL_TIE),
        .rel_out (rel_out)
    );
endmodule

// File: rtl/mag_cmp12.sv
module mag_cmp12
    import cmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic [TOTAL_W-1:0] a_in,
    input  logic [TOTAL_W-1:0] b_in,
    output logic               ser_gt,
    output logic               ser_eq,
    output logic               ser_lt,
    output logic               par_gt,
    output logic               par_eq,
    output logic               par_lt
);
    rel_t ser_rel, par_rel;

    mag_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chain (
        .a_op    (a_in),
        .b_op    (b_in),
        .rel_out (ser_rel)
    );

    mag_tree #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_tree (
        .a_op    (a_in),
        .b_op    (b_in),
        .rel_out (par_rel)
    );

    assign ser_gt = ser_rel.gt;
    assign ser_eq = ser_rel.eq;
    assign ser_lt = ser_rel.lt;
    assign par_gt = par_rel.gt;
    assign par_eq = par_rel.eq;
    assign par_lt = par_rel.lt;
endmodule

// File: tb/tb_mag_cmp12.sv
module tb_mag_cmp12;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [11:0] a_in, b_in;
    logic ser_gt, ser_eq, ser_lt, par_gt, par_eq, par_lt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mag_cmp12 dut (
        .a_in(a_in), .b_in(b_in),
        .ser_gt(ser_gt), .ser_eq(ser_eq), .ser_lt(ser_lt),
        .par_gt(par_gt), .par_eq(par_eq), .par_lt(par_lt)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h actual(gt,eq,lt)=%b expected=%b",
                     req, a_in, b_in, act, exp);
        end
    endtask

    // behavioural reference: integer compare
    task automatic apply(input logic [11:0] a, input logic [11:0] b, input string req);
        int ia, ib;
        logic [2:0] exp;
        @(negedge clk);
        a_in = a;
        b_in = b;
        @(posedge clk);
        #1;
        ia  = int'(a);
        ib  = int'(b);
        exp = {ia > ib, ia == ib, ia < ib};
        check(req, {ser_gt, ser_eq, ser_lt}, exp);
        check(req, {par_gt, par_eq, par_lt}, exp);
        check({req, "_R7"}, {par_gt, par_eq, par_lt}, {ser_gt, ser_eq, ser_lt});
        checks++;
        if ($countones({ser_gt, ser_eq, ser_lt}) != 1 || $countones({par_gt, par_eq, par_lt}) != 1) begin
            fails++;
            $display("FAIL R8 a=%h b=%h actual ser=%b par=%b expected one-hot",
                     a, b, {ser_gt, ser_eq, ser_lt}, {par_gt, par_eq, par_lt});
        end
    endtask

    initial begin
        a_in = '0;
        b_in = '0;
        apply(12'h000, 12'h000, "R9_zero");
        apply(12'hFFF, 12'hFFF, "R9_ones");
        apply(12'h800, 12'h7FF, "R1_msb");
        apply(12'h7FF, 12'h800, "R1_msb_rev");
        apply(12'h001, 12'h000, "R2_lsb");
        apply(12'h000, 12'h001, "R4_lsb");
        apply(12'hA5A, 12'hA5A, "R3_same");
        apply(12'h3F0, 12'h40F, "R5_upper");
        apply(12'h351, 12'h350, "R5_low_decides");
        apply(12'h350, 12'h351, "R5_low_decides_lt");
        apply(12'h0F0, 12'h0E1, "R6_mid");
        apply(12'h10F, 12'h0FF, "R6_top");
        // single differing bit walked across positions, contradicting pattern below
        for (int k = 0; k < 12; k++) begin
            logic [11:0] base, lowmask;
            base    = 12'(($urandom() & 32'hFFF));
            lowmask = 12'((1 << k) - 1);
            apply(base | (12'h1 << k), (base & ~(12'h1 << k)) | lowmask, "R1_walk");
            apply((base & ~(12'h1 << k)) | lowmask, base | (12'h1 << k), "R4_walk");
        end
        // equal upper nibbles with a one-bit perturbation in a lower nibble
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            int bitpos;
            a      = 12'($urandom() & 32'hFFF);
            bitpos = int'($urandom() % 8);
            apply(a, a ^ (12'h1 << bitpos), "R5_cascade");
            apply(a, a, "R3_equal");
        end
        for (int n = 0; n < 1500; n++) begin
            apply(12'($urandom() & 32'hFFF), 12'($urandom() & 32'hFFF), "R2_R4_random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WD_CYCLES; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule